// File: doc/BRIEF.md
# Boundary Scan Test Access Port

This block is the serial test port of a chip. It has no dedicated test-reset pin. A four-wire serial interface carries test clock, mode select, data in and data out. The interface also drives an output-enable for the data-out pad. A sixteen-state controller, stepped by the mode-select line on each rising test-clock edge, moves the port between capturing, shifting and updating either a 3-bit instruction register or one of three data registers. The data registers are a 1-bit bypass stage, a 32-bit identification word and a boundary register whose length is a parameter.

The core presents its pin levels on a parallel capture bus. The port returns two things to the core: the latched boundary contents, for driving pins in test, and a flag that tells the core to float all of its outputs. The port comes out of power-on reset holding the identification instruction. It also returns to that instruction whenever the mode-select line stays high for five clocks, so an idle test bus that floats high keeps the port in reset.

Top module: `tap_port`

## Requirements
- R1: While `porN` is low and directly after it is released, the controller is in its reset state, `tdoEn` is 0, `coreHiZ` is 0, `bsrOut` is all zeros and the instruction is IDCODE (001).
- R2: Five rising `tck` edges with `tms` high reach the reset state from any state, and `tms` held high keeps it there. Entering the reset state reloads IDCODE, which clears `coreHiZ`.
- R3: `tms` and `tdi` are sampled on the rising `tck` edge and `tdo` changes on the falling edge. `tdoEn` is high only while the controller is in Shift-IR or Shift-DR. Every register shifts out its bit 0 first and takes `tdi` into its top bit.
- R4: Capture-IR loads 001 into the instruction shift stage, so an instruction shift emits 1, 0, 0.
- R5: A shifted instruction has no effect until the controller passes Update-IR. Until then the previous instruction stays in force.
- R6: IDCODE (001) selects the 32-bit identification register. Capture-DR loads the parameter `ID_CODE` with bit 0 forced to 1.
- R7: BYPASS (111) and the unassigned codes 011, 101 and 110 select a 1-bit bypass stage. This stage captures 0, so data passes from `tdi` to `tdo` one shift later.
- R8: EXTEST (000), SAMPLE/PRELOAD (100) and SAMPLE-Z (010) select the boundary register. In Capture-DR, bit i loads `pinIn[i]` where `TIED_MASK[i]` is 1 and loads a constant 1 where it is 0.
- R9: Update-DR copies the boundary shift stage to `bsrOut` only under a boundary instruction. Under any other instruction, `bsrOut` is left unchanged.
- R10: `coreHiZ` is 1 exactly while SAMPLE-Z is the instruction in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select; held high when undriven |
| tdi | input | 1 | Serial data in; held high when undriven |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdoEn | output | 1 | Output-enable for the `tdo` pad |
| pinIn | input | BSR_LEN | Parallel pin levels captured into the boundary register |
| bsrOut | output | BSR_LEN | Boundary contents latched at Update-DR |
| coreHiZ | output | 1 | Tells the core to float all of its outputs |

## Verification
A controller in the wrong state shows up on `tdoEn` at the next falling edge. It also shows up as a shift of the wrong length, which the bench detects as a surplus or missing serial bit. A wrong instruction decode reveals itself within one data scan, because the emitted bits carry the captured pattern of the wrong register: the ID word, a leading 0 from bypass, or the masked pin levels. A stale or early instruction update appears on `coreHiZ` one clock after Update-IR. A misplaced update strobe appears on `bsrOut` right after Update-DR.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    TLR, RTI,
    SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tapState_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} drSel_e;

  // strobes from the controller to the register datapath
  typedef struct packed {
    logic inReset;
    logic capDr;
    logic shfDr;
    logic updDr;
    logic capIr;
    logic shfIr;
    logic updIr;
  } tapStrobe_t;
endpackage

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
module tap_ctrl
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       porN,
  input  logic       tms,
  output tapState_e  state,
  output tapStrobe_t stb
);
  tapState_e nextState;

  always_comb begin
    case (state)
      TLR:     nextState = tms ? TLR    : RTI;
      RTI:     nextState = tms ? SEL_DR : RTI;
      SEL_DR:  nextState = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nextState = tms ? EX1_DR : SHF_DR;
      SHF_DR:  nextState = tms ? EX1_DR : SHF_DR;
      EX1_DR:  nextState = tms ? UPD_DR : PAU_DR;
      PAU_DR:  nextState = tms ? EX2_DR : PAU_DR;
      EX2_DR:  nextState = tms ? UPD_DR : SHF_DR;
      UPD_DR:  nextState = tms ? SEL_DR : RTI;
      SEL_IR:  nextState = tms ? TLR    : CAP_IR;
      CAP_IR:  nextState = tms ? EX1_IR : SHF_IR;
      SHF_IR:  nextState = tms ? EX1_IR : SHF_IR;
      EX1_IR:  nextState = tms ? UPD_IR : PAU_IR;
      PAU_IR:  nextState = tms ? EX2_IR : PAU_IR;
      EX2_IR:  nextState = tms ? UPD_IR : SHF_IR;
      UPD_IR:  nextState = tms ? SEL_DR : RTI;
      default: nextState = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) state <= TLR;
    else       state <= nextState;
  end

  // each strobe acts on the rising edge that leaves its state
  always_comb begin
    stb.inReset = (state == TLR);
    stb.capDr   = (state == CAP_DR);
    stb.shfDr   = (state == SHF_DR);
    stb.updDr   = (state == UPD_DR);
    stb.capIr   = (state == CAP_IR);
    stb.shfIr   = (state == SHF_IR);
    stb.updIr   = (state == UPD_IR);
  end
endmodule

// File: rtl/tap_data.sv
`timescale 1ns/1ps
module tap_data
  import tap_pkg::*;
#(
  parameter int                 BSR_LEN   = 8,
  parameter logic [BSR_LEN-1:0] TIED_MASK = 8'h7E,
  parameter logic [31:0]        ID_CODE   = 32'h0A5C_3E4B
) (
  input  logic               tck,
  input  logic               porN,
  input  logic               tdi,
  input  tapStrobe_t         stb,
  input  logic [BSR_LEN-1:0] pinIn,
  output logic               tdo,
  output logic               tdoEn,
  output logic [BSR_LEN-1:0] bsrOut,
  output logic               coreHiZ
);
  localparam int ID_W = 32;
  localparam logic [ID_W-1:0] ID_WORD = {ID_CODE[ID_W-1:1], 1'b1};

  logic [IR_W-1:0]    irReg, irShift;
  logic               bypBit;
  logic [ID_W-1:0]    idShift;
  logic [BSR_LEN-1:0] bsrShift, bsrCapVal;
  drSel_e             drSel;
  logic               tdoNext;

  // instruction decode; every unlisted code falls to bypass
  always_comb begin
    case (irReg)
      OP_IDCODE:                         drSel = SEL_ID;
      OP_EXTEST, OP_SAMPLE, OP_SAMPLEZ:  drSel = SEL_BSR;
      default:                           drSel = SEL_BYP;
    endcase
  end

  assign coreHiZ   = (irReg == OP_SAMPLEZ);
  assign bsrCapVal = (pinIn & TIED_MASK) | ~TIED_MASK;

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) begin
      irReg   <= OP_IDCODE;
      irShift <= IR_CAPTURE;
    end else begin
      if (stb.capIr) irShift <= IR_CAPTURE;
      if (stb.shfIr) irShift <= {tdi, irShift[IR_W-1:1]};
      if (stb.inReset)    irReg <= OP_IDCODE;
      else if (stb.updIr) irReg <= irShift;
    end
  end

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) begin
      bypBit   <= 1'b0;
      idShift  <= ID_WORD;
      bsrShift <= '0;
      bsrOut   <= '0;
    end else begin
      case (drSel)
        SEL_BYP: begin
          if (stb.capDr) bypBit <= 1'b0;
          if (stb.shfDr) bypBit <= tdi;
        end
        SEL_ID: begin
          if (stb.capDr) idShift <= ID_WORD;
          if (stb.shfDr) idShift <= {tdi, idShift[ID_W-1:1]};
        end
        default: begin
          if (stb.capDr) bsrShift <= bsrCapVal;
          if (stb.shfDr) bsrShift <= {tdi, bsrShift[BSR_LEN-1:1]};
          if (stb.updDr) bsrOut   <= bsrShift;
        end
      endcase
    end
  end

  always_comb begin
    if (stb.shfIr) tdoNext = irShift[0];
    else begin
      case (drSel)
        SEL_ID:  tdoNext = idShift[0];
        SEL_BSR: tdoNext = bsrShift[0];
        default: tdoNext = bypBit;
      endcase
    end
  end

  always_ff @(negedge tck or negedge porN) begin
    if (!porN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= tdoNext;
      tdoEn <= stb.shfIr | stb.shfDr;
    end
  end
endmodule

// File: rtl/tap_port.sv
`timescale 1ns/1ps
module tap_port
  import tap_pkg::*;
#(
  parameter int                 BSR_LEN   = 8,
  parameter logic [BSR_LEN-1:0] TIED_MASK = 8'h7E,
  parameter logic [31:0]        ID_CODE   = 32'h0A5C_3E4B
) (
  input  logic               tck,
  input  logic               porN,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdoEn,
  input  logic [BSR_LEN-1:0] pinIn,
  output logic [BSR_LEN-1:0] bsrOut,
  output logic               coreHiZ
);
  tapState_e  tapState;
  tapStrobe_t stb;

  tap_ctrl ctrlI (
    .tck   (tck),
    .porN  (porN),
    .tms   (tms),
    .state (tapState),
    .stb   (stb)
  );

  tap_data #(
    .BSR_LEN   (BSR_LEN),
    .TIED_MASK (TIED_MASK),
    .ID_CODE   (ID_CODE)
  ) dataI (
    .tck     (tck),
    .porN    (porN),
    .tdi     (tdi),
    .stb     (stb),
    .pinIn   (pinIn),
    .tdo     (tdo),
    .tdoEn   (tdoEn),
    .bsrOut  (bsrOut),
    .coreHiZ (coreHiZ)
  );
endmodule

// File: rtl/tap_port_chk.sv
`timescale 1ns/1ps
module tap_port_chk
  import tap_pkg::*;
#(
  parameter int BSR_LEN = 8
) (
  input logic               tck,
  input logic               porN,
  input logic               tms,
  input logic               tdoEn,
  input logic               coreHiZ,
  input logic [BSR_LEN-1:0] bsrOut,
  input tapState_e          tapState
);
  logic [2:0] onesCnt;

  always_ff @(posedge tck or negedge porN) begin
    if (!porN)             onesCnt <= '0;
    else if (!tms)         onesCnt <= '0;
    else if (onesCnt != 5) onesCnt <= onesCnt + 3'd1;
  end

  // R2
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (!porN)
    (onesCnt == 3'd5) |-> (tapState == TLR));

  // R3
  tdo_enable_chk: assert property (@(posedge tck) disable iff (!porN)
    tdoEn == (tapState == SHF_DR || tapState == SHF_IR));

  // R2
  reset_clears_hiz_chk: assert property (@(posedge tck) disable iff (!porN)
    (tapState == TLR) |=> !coreHiZ);

  // R5
  hiz_moves_on_update_chk: assert property (@(posedge tck) disable iff (!porN)
    !$stable(coreHiZ) |-> ($past(tapState) == UPD_IR || $past(tapState) == TLR));

  // R9
  bsr_moves_on_update_chk: assert property (@(posedge tck) disable iff (!porN)
    !$stable(bsrOut) |-> ($past(tapState) == UPD_DR));
endmodule

bind tap_port tap_port_chk #(.BSR_LEN(BSR_LEN)) chkI (
  .tck      (tck),
  .porN     (porN),
  .tms      (tms),
  .tdoEn    (tdoEn),
  .coreHiZ  (coreHiZ),
  .bsrOut   (bsrOut),
  .tapState (tapState)
);

// File: tb/tap_port_test.sv
`timescale 1ns/1ps
module tap_port_test;
  localparam int BL = 8;
  localparam logic [BL-1:0] MASK = 8'h7E;
  localparam logic [31:0]   IDV  = 32'h0A5C_3E4B;

  logic tck = 1'b0, porN = 1'b0, tms = 1'b1, tdi = 1'b1;
  logic [BL-1:0] pinIn = '0;
  logic tdo, tdoEn, coreHiZ;
  logic [BL-1:0] bsrOut;

  int checks = 0, errors = 0;
  bit done = 0;
  bit    expQ[$];
  string tagQ[$];
  bit    hizMid;

  tap_port #(.BSR_LEN(BL), .TIED_MASK(MASK), .ID_CODE(IDV)) uut (
    .tck(tck), .porN(porN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .pinIn(pinIn), .bsrOut(bsrOut), .coreHiZ(coreHiZ));

  always #2 tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected serial bit for each enabled falling edge
  initial begin
    forever begin
      @(negedge tck);
      #2;
      if (tdoEn) begin
        if (expQ.size() == 0) chk(1'b0, "R3 extra enabled tdo cycle", 1, 0);
        else begin
          bit    e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(tdo === e, t, {63'd0, tdo}, {63'd0, e});
        end
      end
    end
  end

  task automatic step(input bit m, input bit d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
  endtask

  task automatic settle();
    @(posedge tck);
    #1;
  endtask

  task automatic scanIr(input logic [2:0] op, output bit midHiZ);
    for (int i = 0; i < 3; i++) begin
      expQ.push_back(i == 0);
      tagQ.push_back("R4 instruction capture pattern");
    end
    step(1, 1); step(1, 1); step(0, 1); step(0, 1);
    for (int i = 0; i < 3; i++) step(i == 2, op[i]);
    step(1, 1);
    midHiZ = coreHiZ;
    step(0, 1);
    settle();
  endtask

  task automatic scanDr(input int n, input logic [63:0] din, input logic [63:0] dexp, input string tag);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(dexp[i]);
      tagQ.push_back(tag);
    end
    step(1, 1); step(0, 1); step(0, 1);
    for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
    step(1, 1); step(0, 1);
    settle();
  endtask

  initial begin
    repeat (3) @(posedge tck);
    #1;
    chk(tdoEn == 1'b0, "R1 tdoEn in reset", tdoEn, 0);
    porN = 1'b1;
    #1;
    chk(coreHiZ == 1'b0, "R1 coreHiZ after reset", coreHiZ, 0);
    chk(bsrOut == '0, "R1 bsrOut after reset", bsrOut, 0);

    // undriven-high TMS keeps the port in reset
    for (int i = 0; i < 6; i++) step(1, 1);
    settle();
    chk(tdoEn == 1'b0, "R2 held reset keeps tdo off", tdoEn, 0);
    step(0, 1);
    settle();

    scanDr(32, 64'hFFFF_FFFF, {32'd0, IDV}, "R6 id word after power-on (R1)");

    scanIr(3'b111, hizMid);
    scanDr(8, 64'hA5, 64'hA5 << 1, "R7 bypass one-stage delay");
    scanIr(3'b011, hizMid);
    scanDr(8, 64'h3C, 64'h3C << 1, "R7 reserved 011 acts as bypass");
    scanIr(3'b110, hizMid);
    scanDr(8, 64'h5B, 64'h5B << 1, "R7 reserved 110 acts as bypass");
    chk(bsrOut == '0, "R9 bypass update leaves bsrOut", bsrOut, 0);

    pinIn = 8'h5A;
    scanIr(3'b100, hizMid);
    chk(coreHiZ == 1'b0, "R10 sample keeps outputs driven", coreHiZ, 0);
    scanDr(8, 64'h3C, 64'hDB, "R8 sample capture of masked pins");
    chk(bsrOut == 8'h3C, "R9 sample update", bsrOut, 8'h3C);
    pinIn = 8'h00;
    scanDr(8, 64'hC3, 64'h81, "R8 untied positions load one");
    chk(bsrOut == 8'hC3, "R9 preload update", bsrOut, 8'hC3);

    pinIn = 8'hFF;
    scanIr(3'b010, hizMid);
    chk(hizMid == 1'b0, "R5 no effect before update", hizMid, 0);
    chk(coreHiZ == 1'b1, "R10 sample-z floats outputs", coreHiZ, 1);
    scanDr(8, 64'h96, 64'hFF, "R8 sample-z selects boundary");
    chk(bsrOut == 8'h96, "R9 sample-z update", bsrOut, 8'h96);

    pinIn = 8'h24;
    scanIr(3'b000, hizMid);
    chk(hizMid == 1'b1, "R5 old instruction holds until update", hizMid, 1);
    chk(coreHiZ == 1'b0, "R10 extest releases outputs", coreHiZ, 0);
    scanDr(8, 64'h11, 64'hA5, "R8 extest capture");
    chk(bsrOut == 8'h11, "R9 extest update", bsrOut, 8'h11);

    // five ones from run-idle with sample-z in force
    scanIr(3'b010, hizMid);
    for (int i = 0; i < 5; i++) step(1, 1);
    settle();
    chk(coreHiZ == 1'b0, "R2 reset reloads IDCODE", coreHiZ, 0);
    step(0, 1);
    settle();
    scanDr(32, 64'h0, {32'd0, IDV}, "R2 id word after tms reset");

    // five ones from pause-dr with bypass in force
    scanIr(3'b111, hizMid);
    step(1, 1); step(0, 1); step(1, 1); step(0, 1);
    for (int i = 0; i < 5; i++) step(1, 1);
    step(0, 1);
    settle();
    scanDr(32, 64'h0, {32'd0, IDV}, "R2 reset from pause-dr");

    chk(expQ.size() == 0, "R3 all expected bits emitted", expQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 run hung actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule